// File: doc/BRIEF.md
# Single-Cycle Parallel Reed-Solomon Encoder

This block encodes a complete Reed-Solomon RS(31,27) message in one clock cycle. The code works over GF(2^5). A whole 27-symbol message arrives on one 135-bit word, qualified by a valid strobe. One clock edge later the full 31-symbol systematic codeword sits in an output register, with its own valid flag.

The 20 parity bits are a fixed linear function of the 135 message bits. That function is worked out at elaboration from the generator polynomial and turned into one XOR tree per parity bit. The datapath therefore has no iterative division and holds no state, apart from the output register. A new message can be accepted on every clock. Because of this, the block suits a link that needs one codeword per cycle.

Top module: `rs_par_enc`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0 and cw_o is all zero, whatever in_valid_i and msg_i carry.
- R2: The encoding is systematic. After a cycle with in_valid_i high, cw_o[154:20] equals the msg_i of that cycle. Message symbol 0 sits at msg_i[134:130] and symbol 26 at msg_i[4:0].
- R3: The field is built on the primitive polynomial x^5+x^2+1, and alpha = 2. The generator g(x) is the product of (x + alpha^j) for j = 1 to 4. The parity field cw_o[19:0] is the remainder of m(x)*x^4 divided by g(x), where symbol 0 is the highest-degree coefficient of m(x). The coefficient of x^3 is at cw_o[19:15], and the coefficient of x^0 is at cw_o[4:0].
- R4: Read cw_o as a polynomial with cw_o[154:150] as the coefficient of x^30. While out_valid_o is high, this polynomial evaluates to zero at alpha^1, alpha^2, alpha^3 and alpha^4.
- R5: out_valid_o equals the in_valid_i of the previous clock cycle. The latency is exactly one cycle.
- R6: A message is accepted on every cycle with in_valid_i high, including back-to-back cycles. Each codeword depends only on its own message.
- R7: A cycle with in_valid_i low leaves cw_o unchanged, even if msg_i changes during that cycle.
- R8: An all-zero message gives an all-zero codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Qualifies msg_i for this cycle |
| msg_i | input | 135 | 27 message symbols, symbol 0 at the MSB end |
| out_valid_o | output | 1 | Qualifies cw_o |
| cw_o | output | 155 | Codeword: message in bits [154:20], parity in bits [19:0] |

## Verification
The register load of a new codeword and the hold of the previous one compete on every edge. The bench interleaves valid and idle cycles at random while msg_i keeps changing. Each edge is then judged on two counts: the parity matches a symbol-serial division model when a new codeword was loaded, and cw_o is bit-for-bit stable when it was not.

The parity is checked separately from the stored message half. It is compared with an independent shift-register model and also tested for roots at alpha^1 to alpha^4. The stimulus is a sweep over every unit message bit, then every nonzero value at every symbol position, then random back-to-back traffic.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int unsigned DEF_SYM_W     = 5;
  localparam int unsigned DEF_N_SYM     = 31;
  localparam int unsigned DEF_K_SYM     = 27;
  localparam int unsigned DEF_PRIM_POLY = 37;  // x^5 + x^2 + 1, top term included

  // GF(2^w) product, poly carries the x^w term
  function automatic int gf_mul(input int a, input int b, input int w, input int poly);
    int r;
    int x;
    r = 0;
    x = a;
    for (int i = 0; i < w; i++) begin
      if (b[i]) r = r ^ x;
      x = x << 1;
      if (x[w]) x = x ^ poly;
    end
    return r;
  endfunction

  function automatic int gf_alpha_pow(input int e, input int w, input int poly);
    int r;
    r = 1;
    for (int i = 0; i < e; i++) r = gf_mul(r, 2, w, poly);
    return r;
  endfunction
endpackage

// File: rtl/rs_parity_net.sv
module rs_parity_net #(
  parameter int unsigned SYM_W     = rs_enc_pkg::DEF_SYM_W,
  parameter int unsigned N_SYM     = rs_enc_pkg::DEF_N_SYM,
  parameter int unsigned K_SYM     = rs_enc_pkg::DEF_K_SYM,
  parameter int unsigned PRIM_POLY = rs_enc_pkg::DEF_PRIM_POLY,
  localparam int unsigned NPAR     = N_SYM - K_SYM,
  localparam int unsigned MSG_W    = K_SYM * SYM_W,
  localparam int unsigned PAR_W    = NPAR * SYM_W
) (
  input  logic [MSG_W-1:0] msg_i,
  output logic [PAR_W-1:0] par_o
);
  import rs_enc_pkg::*;

  // Column k*SYM_W+t, row b: does message bit b feed parity bit t of symbol k
  function automatic logic [PAR_W-1:0][MSG_W-1:0] build_masks();
    logic [PAR_W-1:0][MSG_W-1:0] m;
    int g [0:NPAR];
    int p [0:NPAR-1];
    int root;
    int fb;
    int sym;
    int din;
    m = '0;
    for (int k = 0; k <= int'(NPAR); k++) g[k] = 0;
    g[0] = 1;
    for (int r = 1; r <= int'(NPAR); r++) begin
      root = gf_alpha_pow(r, SYM_W, PRIM_POLY);
      for (int k = NPAR; k >= 1; k--)
        g[k] = g[k-1] ^ gf_mul(g[k], root, SYM_W, PRIM_POLY);
      g[0] = gf_mul(g[0], root, SYM_W, PRIM_POLY);
    end
    for (int b = 0; b < int'(MSG_W); b++) begin
      sym = (MSG_W - 1 - b) / SYM_W;
      for (int k = 0; k < int'(NPAR); k++) p[k] = 0;
      for (int i = sym; i < int'(K_SYM); i++) begin
        din = (i == sym) ? (1 << (b % SYM_W)) : 0;
        fb  = din ^ p[NPAR-1];
        for (int k = NPAR - 1; k >= 1; k--)
          p[k] = p[k-1] ^ gf_mul(g[k], fb, SYM_W, PRIM_POLY);
        p[0] = gf_mul(g[0], fb, SYM_W, PRIM_POLY);
      end
      for (int k = 0; k < int'(NPAR); k++)
        for (int t = 0; t < int'(SYM_W); t++)
          m[k*SYM_W+t][b] = p[k][t];
    end
    return m;
  endfunction

  localparam logic [PAR_W-1:0][MSG_W-1:0] MASK = build_masks();

  for (genvar j = 0; j < PAR_W; j++) begin : g_tree
    assign par_o[j] = ^(msg_i & MASK[j]);
  end
endmodule

// File: rtl/rs_out_reg.sv
module rs_out_reg #(
  parameter int unsigned DATA_W = 155
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/rs_par_enc.sv
module rs_par_enc #(
  parameter int unsigned SYM_W     = rs_enc_pkg::DEF_SYM_W,
  parameter int unsigned N_SYM     = rs_enc_pkg::DEF_N_SYM,
  parameter int unsigned K_SYM     = rs_enc_pkg::DEF_K_SYM,
  parameter int unsigned PRIM_POLY = rs_enc_pkg::DEF_PRIM_POLY,
  localparam int unsigned MSG_W    = K_SYM * SYM_W,
  localparam int unsigned CW_W     = N_SYM * SYM_W,
  localparam int unsigned PAR_W    = CW_W - MSG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [MSG_W-1:0] msg_i,
  output logic             out_valid_o,
  output logic [CW_W-1:0]  cw_o
);
  logic [PAR_W-1:0] par;

  rs_parity_net #(
    .SYM_W(SYM_W), .N_SYM(N_SYM), .K_SYM(K_SYM), .PRIM_POLY(PRIM_POLY)
  ) u_par (
    .msg_i(msg_i),
    .par_o(par)
  );

  rs_out_reg #(.DATA_W(CW_W)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (in_valid_i),
    .d_i    ({msg_i, par}),
    .valid_o(out_valid_o),
    .q_o    (cw_o)
  );
endmodule

// File: rtl/rs_par_enc_chk.sv
module rs_par_enc_chk #(
  parameter int unsigned SYM_W     = rs_enc_pkg::DEF_SYM_W,
  parameter int unsigned N_SYM     = rs_enc_pkg::DEF_N_SYM,
  parameter int unsigned K_SYM     = rs_enc_pkg::DEF_K_SYM,
  parameter int unsigned PRIM_POLY = rs_enc_pkg::DEF_PRIM_POLY,
  localparam int unsigned MSG_W    = K_SYM * SYM_W,
  localparam int unsigned CW_W     = N_SYM * SYM_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [MSG_W-1:0] msg_i,
  input logic             out_valid_o,
  input logic [CW_W-1:0]  cw_o
);
  import rs_enc_pkg::*;

  function automatic logic roots_ok(input logic [CW_W-1:0] c);
    int a;
    int s;
    for (int j = 1; j <= int'(N_SYM - K_SYM); j++) begin
      a = gf_alpha_pow(j, SYM_W, PRIM_POLY);
      s = 0;
      for (int i = 0; i < int'(N_SYM); i++)
        s = gf_mul(s, a, SYM_W, PRIM_POLY) ^ int'(c[CW_W-1-SYM_W*i -: SYM_W]);
      if (s != 0) return 1'b0;
    end
    return 1'b1;
  endfunction

  logic synd_ok;
  always_comb synd_ok = roots_ok(cw_o);

  always @(negedge clk_i)
    if (!rst_ni) assert_reset_clear_R1: assert (!out_valid_o && cw_o == '0);

  assert_msg_copy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> cw_o[CW_W-1 -: MSG_W] == $past(msg_i));

  assert_roots_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> synd_ok);

  assert_valid_lat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  assert_idle_lat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(cw_o));
endmodule

bind rs_par_enc rs_par_enc_chk #(
  .SYM_W(SYM_W), .N_SYM(N_SYM), .K_SYM(K_SYM), .PRIM_POLY(PRIM_POLY)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .msg_i(msg_i),
  .out_valid_o(out_valid_o), .cw_o(cw_o)
);

// File: tb/tb_rs_par_enc.sv
module tb_rs_par_enc;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         vin = 1'b0;
  logic [134:0] msg = '0;
  logic         vout;
  logic [154:0] cw;

  int n_cmp = 0;
  int n_bad = 0;
  int gb [0:4];
  logic [154:0] exp_cw = '0;
  logic         exp_v  = 1'b0;
  logic [134:0] exp_msg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_par_enc dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(vin), .msg_i(msg),
    .out_valid_o(vout), .cw_o(cw)
  );

  function automatic int bmul(input int a, input int b);
    int r = 0;
    int x = a;
    for (int i = 0; i < 5; i++) begin
      if (b[i]) r ^= x;
      x = x << 1;
      if (x[5]) x ^= 37;
    end
    return r;
  endfunction

  // symbol-serial division model
  function automatic logic [154:0] ref_cw(input logic [134:0] m);
    int p [0:3];
    int fb;
    for (int k = 0; k < 4; k++) p[k] = 0;
    for (int i = 0; i < 27; i++) begin
      fb = int'(m[134-5*i -: 5]) ^ p[3];
      p[3] = p[2] ^ bmul(gb[3], fb);
      p[2] = p[1] ^ bmul(gb[2], fb);
      p[1] = p[0] ^ bmul(gb[1], fb);
      p[0] = bmul(gb[0], fb);
    end
    return {m, p[3][4:0], p[2][4:0], p[1][4:0], p[0][4:0]};
  endfunction

  function automatic bit has_roots(input logic [154:0] c);
    int a = 1;
    int s;
    for (int j = 1; j <= 4; j++) begin
      a = bmul(a, 2);
      s = 0;
      for (int i = 0; i < 31; i++) s = bmul(s, a) ^ int'(c[154-5*i -: 5]);
      if (s != 0) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [154:0] act, input logic [154:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [134:0] rnd_msg();
    logic [134:0] m;
    for (int i = 0; i < 27; i++) m[134-5*i -: 5] = 5'($urandom_range(0, 31));
    return m;
  endfunction

  // called at a negedge; drives, then samples at the next negedge
  task automatic step(input logic v, input logic [134:0] m, input string tag);
    vin = v;
    msg = m;
    if (v) begin
      exp_cw  = ref_cw(m);
      exp_msg = m;
    end
    exp_v = v;
    @(negedge clk);
    check(vout == exp_v, "R5", 155'(vout), 155'(exp_v));
    check(cw == exp_cw, tag, cw, exp_cw);
    if (exp_v) begin
      check(cw[154:20] == exp_msg, "R2", 155'(cw[154:20]), 155'(exp_msg));
      check(has_roots(cw), "R4", cw, exp_cw);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [134:0] m;
    for (int k = 0; k < 5; k++) gb[k] = 0;
    gb[0] = 1;
    begin
      int root = 1;
      for (int r = 1; r <= 4; r++) begin
        root = bmul(root, 2);
        for (int k = 4; k >= 1; k--) gb[k] = gb[k-1] ^ bmul(gb[k], root);
        gb[0] = bmul(gb[0], root);
      end
    end

    // R1: reset dominates stimulus
    vin = 1'b1;
    msg = {135{1'b1}};
    repeat (3) @(negedge clk);
    check(vout == 1'b0, "R1", 155'(vout), '0);
    check(cw == '0, "R1", cw, '0);
    vin = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R8: zero message
    step(1'b1, '0, "R8");

    // R3: every unit message bit, back to back
    for (int b = 0; b < 135; b++) step(1'b1, 135'(1) << b, "R3");

    // R6: every nonzero value at every symbol position, back to back
    for (int s = 0; s < 27; s++)
      for (int v = 1; v < 32; v++) begin
        m = '0;
        m[134-5*s -: 5] = 5'(v);
        step(1'b1, m, "R6");
      end

    step(1'b1, {135{1'b1}}, "R3");

    // R7: idle cycles with changing message keep the codeword
    step(1'b1, rnd_msg(), "R3");
    for (int i = 0; i < 6; i++) step(1'b0, rnd_msg(), "R7");

    // R6/R7: random mix of load and hold
    for (int i = 0; i < 3000; i++)
      step(($urandom_range(0, 3) != 0), rnd_msg(), "R6");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule